// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the combinational logic core of one function block in a programmable logic device. It receives a set of routed input signals and derives two literals from each: the signal itself and its complement. A product-term plane then forms each product term as the AND of the literals that its configuration row includes. A sum plane forms each macrocell sum as the OR of the product terms that its configuration column includes.

Both planes use inverted fuse polarity. A cleared bit connects a literal or a term. A set bit disconnects it. An erased (all-ones) configuration therefore gives constant-true product terms and constant-false sums. The sum plane stores its columns in reverse macrocell order, and the block undoes that reversal so that `sum_o` is indexed by macrocell number.

There is no clock and no state. Both outputs follow the inputs in the same evaluation. Configuration storage and loading, registers and output enables belong to neighbouring blocks.

Top module: `pta_core`

## Requirements
- R1: Literal `2k` of the literal vector is routed signal `k` uncomplemented, and literal `2k+1` is routed signal `k` inverted.
- R2: A product-term row whose bits are all 1 yields a product term of 1, whatever the routed signals are.
- R3: A 0 bit in a product-term row includes its literal in the AND, and a 1 bit replaces it with constant one. A row that includes both literals of one signal always yields 0.
- R4: Product term `n` (`pterm_o[n]`) is configured by `and_cfg_i[n*80 +: 80]`, where bit `b` of that slice is literal `b`.
- R5: A sum-plane column whose bits are all 1 yields a sum of 0, whatever the product terms are.
- R6: A 0 at bit `r` of a sum-plane column includes product term `r` in that column's OR, and a 1 bit replaces it with constant zero.
- R7: Sum-plane column `c` is `or_cfg_i[c*56 +: 56]` and drives macrocell `15-c`, which is output `sum_o[15-c]`.
- R8: The block is purely combinational. Outputs settle after an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sig_i | input | 40 | Routed input signals |
| and_cfg_i | input | 4480 | Product-term plane configuration, 56 rows of 80 bits |
| or_cfg_i | input | 896 | Sum plane configuration, 16 columns of 56 bits |
| pterm_o | output | 56 | Product term values |
| sum_o | output | 16 | Sums, indexed by macrocell number |

## Verification
The assertions are immediate checks that are evaluated whenever the combinational logic settles. They assume that every input carries only 0 or 1, with no X or Z on any routed signal or configuration bit. The stimulus drives every input bit to a known value from time zero, both in the random configurations and in the directed ones. The random configurations are mostly ones with a few cleared bits per row and per column, so that product terms and sums take both values rather than collapsing to constants.

// File: rtl/pta_pkg.sv
package pta_pkg;
  parameter int unsigned N_SIG = 40;
  parameter int unsigned N_PT  = 56;
  parameter int unsigned N_MC  = 16;
  parameter int unsigned N_LIT = 2 * N_SIG;
endpackage

// File: rtl/pta_lit_gen.sv
module pta_lit_gen #(
  parameter int unsigned N_SIG = pta_pkg::N_SIG,
  localparam int unsigned N_LIT = 2 * N_SIG
) (
  input  logic [N_SIG-1:0] sig_i,
  output logic [N_LIT-1:0] lit_o
);
  for (genvar k = 0; k < N_SIG; k++) begin : g_pair
    assign lit_o[2*k]   = sig_i[k];
    assign lit_o[2*k+1] = ~sig_i[k];
  end
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
  parameter int unsigned N_LIT = pta_pkg::N_LIT,
  parameter int unsigned N_PT  = pta_pkg::N_PT
) (
  input  logic [N_LIT-1:0]      lit_i,
  input  logic [N_PT*N_LIT-1:0] cfg_i,
  output logic [N_PT-1:0]       pterm_o
);
  for (genvar n = 0; n < N_PT; n++) begin : g_row
    // set bit forces the literal input high
    assign pterm_o[n] = &(lit_i | cfg_i[n*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int unsigned N_PT = pta_pkg::N_PT,
  parameter int unsigned N_MC = pta_pkg::N_MC
) (
  input  logic [N_PT-1:0]      pterm_i,
  input  logic [N_MC*N_PT-1:0] cfg_i,
  output logic [N_MC-1:0]      sum_o
);
  for (genvar c = 0; c < N_MC; c++) begin : g_col
    // column c feeds macrocell N_MC-1-c
    assign sum_o[N_MC-1-c] = |(pterm_i & ~cfg_i[c*N_PT +: N_PT]);
  end
endmodule

// File: rtl/pta_core.sv
module pta_core #(
  parameter int unsigned N_SIG = pta_pkg::N_SIG,
  parameter int unsigned N_PT  = pta_pkg::N_PT,
  parameter int unsigned N_MC  = pta_pkg::N_MC,
  localparam int unsigned N_LIT = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]      sig_i,
  input  logic [N_PT*N_LIT-1:0] and_cfg_i,
  input  logic [N_MC*N_PT-1:0]  or_cfg_i,
  output logic [N_PT-1:0]       pterm_o,
  output logic [N_MC-1:0]       sum_o
);
  logic [N_LIT-1:0] lit;

  pta_lit_gen #(.N_SIG(N_SIG)) u_lit (
    .sig_i (sig_i),
    .lit_o (lit)
  );

  pta_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_and (
    .lit_i   (lit),
    .cfg_i   (and_cfg_i),
    .pterm_o (pterm_o)
  );

  pta_or_plane #(.N_PT(N_PT), .N_MC(N_MC)) u_or (
    .pterm_i (pterm_o),
    .cfg_i   (or_cfg_i),
    .sum_o   (sum_o)
  );

  always_comb begin
    for (int n = 0; n < N_PT; n++) begin
      // R2
      and_ones_true_chk: assert (!(&and_cfg_i[n*N_LIT +: N_LIT]) || pterm_o[n])
        else $error("erased row %0d not true", n);
      for (int k = 0; k < N_SIG; k++) begin
        // R3
        contra_false_chk: assert (and_cfg_i[n*N_LIT+2*k] || and_cfg_i[n*N_LIT+2*k+1] || !pterm_o[n])
          else $error("row %0d with both literals of %0d is true", n, k);
      end
    end
    for (int c = 0; c < N_MC; c++) begin
      // R5
      or_ones_zero_chk: assert (!(&or_cfg_i[c*N_PT +: N_PT]) || !sum_o[N_MC-1-c])
        else $error("erased column %0d not false", c);
      for (int r = 0; r < N_PT; r++) begin
        // R7
        single_term_chk: assert (!($countones(~or_cfg_i[c*N_PT +: N_PT]) == 1 && !or_cfg_i[c*N_PT+r])
                                 || sum_o[N_MC-1-c] == pterm_o[r])
          else $error("column %0d single term %0d mismatch", c, r);
      end
    end
    // R6
    no_term_no_sum_chk: assert (|pterm_o || !(|sum_o))
      else $error("sum high with no product term");
  end
endmodule

// File: tb/tb_pta_core.sv
module tb_pta_core;
  localparam int unsigned N_SIG = 40;
  localparam int unsigned N_PT  = 56;
  localparam int unsigned N_MC  = 16;
  localparam int unsigned N_LIT = 80;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 12;
  // {seed, and cleared bits per row, or cleared bits per column}
  localparam logic [47:0] VEC [NV] = '{
    {16'd11, 16'd1, 16'd1}, {16'd23, 16'd2, 16'd3}, {16'd37, 16'd3, 16'd5},
    {16'd41, 16'd1, 16'd8}, {16'd59, 16'd2, 16'd2}, {16'd67, 16'd4, 16'd6},
    {16'd71, 16'd1, 16'd12}, {16'd83, 16'd2, 16'd1}, {16'd97, 16'd3, 16'd9},
    {16'd101, 16'd0, 16'd4}, {16'd113, 16'd1, 16'd20}, {16'd127, 16'd2, 16'd7}
  };

  logic clk = 1'b0;
  logic [N_SIG-1:0]      sig;
  logic [N_PT*N_LIT-1:0] and_cfg;
  logic [N_MC*N_PT-1:0]  or_cfg;
  logic [N_PT-1:0]       pterm;
  logic [N_MC-1:0]       sum;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pta_core dut (
    .sig_i     (sig),
    .and_cfg_i (and_cfg),
    .or_cfg_i  (or_cfg),
    .pterm_o   (pterm),
    .sum_o     (sum)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N_PT-1:0] ref_pterm();
    logic [N_PT-1:0] p;
    for (int n = 0; n < N_PT; n++) begin
      p[n] = 1'b1;
      for (int k = 0; k < N_SIG; k++) begin
        if (!and_cfg[n*N_LIT+2*k]   && !sig[k]) p[n] = 1'b0;
        if (!and_cfg[n*N_LIT+2*k+1] &&  sig[k]) p[n] = 1'b0;
      end
    end
    return p;
  endfunction

  function automatic logic [N_MC-1:0] ref_sum(input logic [N_PT-1:0] p);
    logic [N_MC-1:0] s;
    for (int m = 0; m < N_MC; m++) begin
      s[m] = 1'b0;
      for (int r = 0; r < N_PT; r++)
        if (!or_cfg[(N_MC-1-m)*N_PT+r] && p[r]) s[m] = 1'b1;
    end
    return s;
  endfunction

  task automatic settle_and_compare(input string rp, input string rs);
    logic [N_PT-1:0] ep;
    logic [N_MC-1:0] es;
    @(negedge clk);
    ep = ref_pterm();
    es = ref_sum(ep);
    check(pterm === ep, rp, 64'(pterm), 64'(ep));
    check(sum === es, rs, 64'(sum), 64'(es));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail = n_fail + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int dummy;
    sig = '0; and_cfg = '1; or_cfg = '1;
    // erased configuration state: R2 and R5
    @(posedge clk); sig = {8'hA5, 32'h3C96_0F1E};
    @(negedge clk);
    check(pterm === '1, "R2 erased row", 64'(pterm), 64'(56'hFF_FFFF_FFFF_FFFF));
    check(sum === '0, "R5 erased column", 64'(sum), 64'h0);

    // random table: R1 R3 R4 R6 R7
    for (int v = 0; v < NV; v++) begin
      @(posedge clk);
      dummy = $urandom(int'(VEC[v][47:32]));
      sig = {8'($urandom), $urandom};
      and_cfg = '1; or_cfg = '1;
      for (int n = 0; n < N_PT; n++)
        for (int z = 0; z < int'(VEC[v][31:16]); z++)
          and_cfg[n*N_LIT + $urandom_range(N_LIT-1)] = 1'b0;
      for (int c = 0; c < N_MC; c++)
        for (int z = 0; z < int'(VEC[v][15:0]); z++)
          or_cfg[c*N_PT + $urandom_range(N_PT-1)] = 1'b0;
      settle_and_compare("R1 R3 R4 random pterm", "R6 R7 random sum");
    end

    // R1 R4: true literal of signal 5 in row 7
    @(posedge clk); and_cfg = '1; or_cfg = '1; sig = '0; sig[5] = 1'b1;
    and_cfg[7*N_LIT + 10] = 1'b0;
    @(negedge clk);
    check(pterm === '1, "R1 R4 true literal high", 64'(pterm), 64'(56'hFF_FFFF_FFFF_FFFF));
    @(posedge clk); sig[5] = 1'b0;
    @(negedge clk);
    check(pterm === ~(56'd1 << 7), "R1 R4 true literal low", 64'(pterm), 64'(~(56'd1 << 7)));
    // R1: complement literal of signal 3 in row 9
    @(posedge clk); and_cfg = '1; and_cfg[9*N_LIT + 7] = 1'b0; sig = '1;
    @(negedge clk);
    check(pterm === ~(56'd1 << 9), "R1 complement literal", 64'(pterm), 64'(~(56'd1 << 9)));
    // R3: contradiction in row 0, both signal values
    @(posedge clk); and_cfg = '1; and_cfg[0] = 1'b0; and_cfg[1] = 1'b0; sig = '0;
    @(negedge clk);
    check(pterm[0] === 1'b0, "R3 contradiction sig0=0", 64'(pterm[0]), 64'h0);
    @(posedge clk); sig[0] = 1'b1;
    @(negedge clk);
    check(pterm[0] === 1'b0, "R3 contradiction sig0=1", 64'(pterm[0]), 64'h0);
    // R7: column 0 -> macrocell 15, column 15 -> macrocell 0
    @(posedge clk); and_cfg = '1; or_cfg = '1; or_cfg[0*N_PT + 20] = 1'b0;
    @(negedge clk);
    check(sum === 16'h8000, "R7 column 0", 64'(sum), 64'h8000);
    @(posedge clk); or_cfg = '1; or_cfg[15*N_PT + 3] = 1'b0;
    @(negedge clk);
    check(sum === 16'h0001, "R7 column 15", 64'(sum), 64'h0001);
    // R6: included term false gives 0; excluded true terms ignored
    @(posedge clk); and_cfg[3*N_LIT + 0] = 1'b0; and_cfg[3*N_LIT + 1] = 1'b0;
    @(negedge clk);
    check(sum === 16'h0000, "R6 included term false", 64'(sum), 64'h0);
    // R8: change away from any clock edge, sample 1ns later
    @(negedge clk); #2ns; and_cfg = '1;
    #1ns;
    check(sum === 16'h0001, "R8 combinational response", 64'(sum), 64'h0001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule